// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Line Errors

This block recovers bytes from an asynchronous serial line that rests high. An external divider supplies a one-cycle enable at sixteen times the bit rate. The receiver passes the line through a short synchronizer. It treats a high-to-low transition as the beginning of a character, confirms it at mid-bit, and then takes one sample at the centre of every following bit. Data arrives least significant bit first. An optional parity bit follows the data, and one stop bit ends the character.

When a character completes, the byte is presented together with a ready flag. The parity and framing checks are reported in the same clock as the ready flag. Those two error flags and an overrun flag are sticky. Reading the byte lowers only the ready flag, and only a separate status-clear strobe removes the error flags. Baud generation, bus decoding, interrupts and buffering are left to the surrounding logic.

Top module: `serial_rx_flags`

## Requirements
- R1: After reset, ready_o, par_err_o, frm_err_o and ovr_o are 0 and data_o is 0.
- R2: A character starts only on a high-to-low transition of the synchronized line. A line that is held low after a character, or from reset, starts no new character until it has been seen high on a tick.
- R3: After the start edge, the line is re-sampled on the eighth tick. If it has returned high, the character is abandoned and ready_o does not rise.
- R4: Each data bit is sampled once, sixteen ticks after the previous sample point, and the bits fill data_o from bit 0 upward. At the end of the stop bit, data_o takes the byte and ready_o rises.
- R5: With par_en_i=1, a parity bit follows the data. par_mode_i selects the expected parity value: 0 gives even (parity bit equals the XOR of the data), 1 gives odd, 2 gives a constant 0 and 3 gives a constant 1. A mismatch sets par_err_o in the same cycle that ready_o is set.
- R6: With par_en_i=0, no parity bit is expected, the stop bit directly follows bit 7, and par_err_o is never set.
- R7: A stop bit sampled as 0 sets frm_err_o in the same cycle that ready_o is set.
- R8: par_err_o, frm_err_o and ovr_o stay set through reads. A clr_sts_i pulse clears them. If a new error coincides with the clear, the new error wins.
- R9: An rd_i pulse clears ready_o on the next clock and leaves data_o unchanged.
- R10: A character that completes while ready_o is 1 and rd_i is 0 overwrites data_o and sets ovr_o.
- R11: The receiver's bit timing advances only on clocks where tick_i is 1, so the character timing scales with the tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling enable, 16 per bit |
| par_en_i | input | 1 | Parity bit present |
| par_mode_i | input | 2 | 0 even, 1 odd, 2 constant 0, 3 constant 1 |
| rd_i | input | 1 | Byte read strobe |
| clr_sts_i | input | 1 | Sticky status clear strobe |
| data_o | output | 8 | Last received byte |
| ready_o | output | 1 | Byte waiting |
| par_err_o | output | 1 | Sticky parity error |
| frm_err_o | output | 1 | Sticky framing error |
| ovr_o | output | 1 | Sticky overrun |

## Verification
The bench builds the block with its defaults: 8 data bits, 16 ticks per bit and a two-stage synchronizer. It drives the tick both on every clock and on every third clock. Ticking on every clock keeps a character under 200 cycles, so all four parity modes, bad stop bits, glitches, stuck-low lines and back-to-back overruns fit in one short run. Ticking on every third clock makes the reference model prove that nothing advances between ticks.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_EVEN  = 2'd0,
    PAR_ODD   = 2'd1,
    PAR_SPACE = 2'd2,
    PAR_MARK  = 2'd3
  } par_mode_e;

  // expected parity bit given the XOR of the data bits
  function automatic logic par_expect(par_mode_e mode, logic data_xor);
    unique case (mode)
      PAR_EVEN:  return data_xor;
      PAR_ODD:   return ~data_xor;
      PAR_SPACE: return 1'b0;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b1;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              tick_i,
  input  logic              par_en_i,
  input  logic [1:0]        par_mode_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_bad_o,
  output logic              frm_bad_o
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              pbit_q;
  logic              armed_q;
  logic              done_q;
  logic [DATA_W-1:0] dout_q;
  logic              pbad_q;
  logic              fbad_q;
  logic              par_want;

  assign par_want = par_expect(par_mode_e'(par_mode_i), ^sh_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      dout_q  <= '0;
      pbad_q  <= 1'b0;
      fbad_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            // arming needs the line seen high, so a stuck-low line never restarts
            if (armed_q && !line_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
              armed_q <= 1'b0;
            end else begin
              armed_q <= line_i;
            end
          end
          ST_START: begin
            if (cnt_q == CNT_MID) begin
              cnt_q <= '0;
              idx_q <= '0;
              state_q <= line_i ? ST_IDLE : ST_DATA;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          ST_DATA: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q <= '0;
              sh_q  <= {line_i, sh_q[DATA_W-1:1]};
              if (idx_q == IDX_LAST) state_q <= par_en_i ? ST_PAR : ST_STOP;
              else                   idx_q   <= idx_q + IDX_W'(1);
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          ST_PAR: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q   <= '0;
              pbit_q  <= line_i;
              state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          ST_STOP: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q   <= '0;
              done_q  <= 1'b1;
              dout_q  <= sh_q;
              fbad_q  <= ~line_i;
              pbad_q  <= par_en_i && (pbit_q != par_want);
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o    = done_q;
  assign data_o    = dout_q;
  assign par_bad_o = pbad_q;
  assign frm_bad_o = fbad_q;

  assert_hold_without_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(state_q) && $stable(cnt_q) && $stable(idx_q)));

  assert_glitch_abort_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && cnt_q == CNT_MID && line_i) |=> (state_q == ST_IDLE));

  assert_done_after_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(state_q) == ST_STOP));

  assert_no_par_err_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !$past(par_en_i)) |-> !pbad_q);

endmodule

// File: rtl/rx_status.sv
module rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_bad_i,
  input  logic              frm_bad_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              ovr_o
);

  logic [DATA_W-1:0] data_q;
  logic ready_q, perr_q, ferr_q, ovr_q;
  logic ovr_set;

  assign ovr_set = done_i && ready_q && !rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (done_i) begin
        data_q  <= data_i;
        ready_q <= 1'b1;
      end else if (rd_i) begin
        ready_q <= 1'b0;
      end
      // new errors take priority over a coincident clear
      perr_q <= (perr_q && !clr_i) || (done_i && par_bad_i);
      ferr_q <= (ferr_q && !clr_i) || (done_i && frm_bad_i);
      ovr_q  <= (ovr_q  && !clr_i) || ovr_set;
    end
  end

  assign data_o    = data_q;
  assign ready_o   = ready_q;
  assign par_err_o = perr_q;
  assign frm_err_o = ferr_q;
  assign ovr_o     = ovr_q;

  assert_perr_with_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(perr_q) |-> ready_q);

  assert_ferr_with_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ferr_q) |-> ready_q);

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((perr_q || ferr_q || ovr_q) && !clr_i) |=> (perr_q || ferr_q || ovr_q));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !done_i) |=> !(perr_q || ferr_q || ovr_q));

  assert_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> (!ready_q && $stable(data_q)));

  assert_overrun_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(ready_q));

endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              par_en_i,
  input  logic [1:0]        par_mode_i,
  input  logic              rd_i,
  input  logic              clr_sts_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              ovr_o
);

  logic              line;
  logic              done;
  logic [DATA_W-1:0] frame_data;
  logic              par_bad;
  logic              frm_bad;

  rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (line)
  );

  rx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (line),
    .tick_i    (tick_i),
    .par_en_i  (par_en_i),
    .par_mode_i(par_mode_i),
    .done_o    (done),
    .data_o    (frame_data),
    .par_bad_o (par_bad),
    .frm_bad_o (frm_bad)
  );

  rx_status #(.DATA_W(DATA_W)) i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .data_i   (frame_data),
    .par_bad_i(par_bad),
    .frm_bad_i(frm_bad),
    .rd_i     (rd_i),
    .clr_i    (clr_sts_i),
    .data_o   (data_o),
    .ready_o  (ready_o),
    .par_err_o(par_err_o),
    .frm_err_o(frm_err_o),
    .ovr_o    (ovr_o)
  );

endmodule

// File: tb/test_serial_rx_flags.sv
`timescale 1ns/1ps
module test_serial_rx_flags;

  localparam int DW   = 8;
  localparam int OVS  = 16;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_i = 1'b1;
  logic tick_i = 1'b0;
  logic par_en_i = 1'b0;
  logic [1:0] par_mode_i = 2'd0;
  logic rd_i = 1'b0;
  logic clr_sts_i = 1'b0;
  logic [DW-1:0] data_o;
  logic ready_o, par_err_o, frm_err_o, ovr_o;

  int n_chk = 0;
  int n_fail = 0;
  int tdiv = 1;
  int tcnt = 0;

  always #2.5 clk = ~clk;

  serial_rx_flags #(.DATA_W(DW), .OVS(OVS), .SYNC_STAGES(SYNC)) i_serial_rx_flags (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx_i), .tick_i(tick_i),
    .par_en_i(par_en_i), .par_mode_i(par_mode_i), .rd_i(rd_i), .clr_sts_i(clr_sts_i),
    .data_o(data_o), .ready_o(ready_o), .par_err_o(par_err_o),
    .frm_err_o(frm_err_o), .ovr_o(ovr_o)
  );

  always @(negedge clk) begin
    tick_i = (tcnt == 0);
    tcnt = (tcnt + 1) % tdiv;
  end

  // ---------------- behavioural reference model ----------------
  int m_state, m_cnt, m_idx;
  bit m_armed, m_pbit, m_done, m_dpe, m_dfe, line;
  bit [DW-1:0] m_sh, m_dd;
  bit [DW-1:0] e_data;
  bit e_rdy, e_pe, e_fe, e_ov, want;
  bit hist[$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_cnt = 0; m_idx = 0; m_armed = 0; m_pbit = 0;
      m_done = 0; m_dpe = 0; m_dfe = 0; m_sh = '0; m_dd = '0;
      e_data = '0; e_rdy = 0; e_pe = 0; e_fe = 0; e_ov = 0;
      hist.delete();
      for (int i = 0; i < SYNC; i++) hist.push_back(1'b1);
    end else begin
      line = hist[SYNC-1];
      if (clr_sts_i) begin e_pe = 0; e_fe = 0; e_ov = 0; end
      if (m_done) begin
        if (e_rdy && !rd_i) e_ov = 1;
        e_rdy = 1; e_data = m_dd;
        if (m_dpe) e_pe = 1;
        if (m_dfe) e_fe = 1;
      end else if (rd_i) e_rdy = 0;
      m_done = 0;
      if (tick_i) begin
        case (m_state)
          0: if (m_armed && !line) begin m_state = 1; m_cnt = 0; m_armed = 0; end
             else m_armed = line;
          1: if (m_cnt == OVS/2 - 1) begin m_cnt = 0; m_idx = 0; m_state = line ? 0 : 2; end
             else m_cnt++;
          2: if (m_cnt == OVS - 1) begin
               m_cnt = 0; m_sh = {line, m_sh[DW-1:1]};
               if (m_idx == DW - 1) m_state = par_en_i ? 3 : 4; else m_idx++;
             end else m_cnt++;
          3: if (m_cnt == OVS - 1) begin m_cnt = 0; m_pbit = line; m_state = 4; end
             else m_cnt++;
          default: if (m_cnt == OVS - 1) begin
               m_cnt = 0; m_done = 1; m_dd = m_sh; m_dfe = !line;
               case (par_mode_i)
                 2'd0: want = ^m_sh;
                 2'd1: want = ~^m_sh;
                 2'd2: want = 1'b0;
                 default: want = 1'b1;
               endcase
               m_dpe = par_en_i && (m_pbit != want);
               m_state = 0;
             end else m_cnt++;
        endcase
      end
      hist.push_front(rx_i);
      void'(hist.pop_back());
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      n_chk++;
      if (data_o !== e_data || ready_o !== e_rdy || par_err_o !== e_pe ||
          frm_err_o !== e_fe || ovr_o !== e_ov) begin
        n_fail++;
        if (data_o !== e_data)   $display("FAIL R4 model data actual=%h expected=%h t=%0t", data_o, e_data, $time);
        if (ready_o !== e_rdy)   $display("FAIL R9 model ready actual=%b expected=%b t=%0t", ready_o, e_rdy, $time);
        if (par_err_o !== e_pe)  $display("FAIL R5 model par_err actual=%b expected=%b t=%0t", par_err_o, e_pe, $time);
        if (frm_err_o !== e_fe)  $display("FAIL R7 model frm_err actual=%b expected=%b t=%0t", frm_err_o, e_fe, $time);
        if (ovr_o !== e_ov)      $display("FAIL R10 model ovr actual=%b expected=%b t=%0t", ovr_o, e_ov, $time);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (tick_i) k++;
    end
    @(negedge clk);
  endtask

  task automatic hold_bit(bit v);
    rx_i = v;
    wait_ticks(OVS);
  endtask

  task automatic send(bit [DW-1:0] d, bit with_par, bit pbit, bit stopv, bit end_lvl);
    hold_bit(1'b0);
    for (int i = 0; i < DW; i++) hold_bit(d[i]);
    if (with_par) hold_bit(pbit);
    hold_bit(stopv);
    rx_i = end_lvl;
    wait_ticks(2 * OVS);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_i = 1; @(negedge clk); rd_i = 0; @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_sts_i = 1; @(negedge clk); clr_sts_i = 0; @(negedge clk);
  endtask

  task automatic run_all();
    repeat (4) @(negedge clk);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    chk("R1 ready", ready_o, 0);
    chk("R1 flags", {par_err_o, frm_err_o, ovr_o}, 0);
    chk("R1 data", data_o, 0);
    wait_ticks(OVS);

    // R6 / R4: no parity
    par_en_i = 0;
    send(8'hA5, 0, 0, 1, 1);
    chk("R4 data", data_o, 8'hA5);
    chk("R4 ready", ready_o, 1);
    chk("R6 no par err", par_err_o, 0);
    pulse_rd();
    chk("R9 ready cleared", ready_o, 0);
    chk("R9 data kept", data_o, 8'hA5);

    // R5: parity modes, good then bad
    par_en_i = 1;
    par_mode_i = 2'd0; send(8'h3C, 1, ^8'h3C, 1, 1);
    chk("R5 even good", par_err_o, 0); pulse_rd();
    par_mode_i = 2'd1; send(8'h81, 1, ~^8'h81, 1, 1);
    chk("R5 odd good", par_err_o, 0); pulse_rd();
    par_mode_i = 2'd2; send(8'h7E, 1, 1'b0, 1, 1);
    chk("R5 space good", par_err_o, 0); pulse_rd();
    par_mode_i = 2'd3; send(8'h01, 1, 1'b1, 1, 1);
    chk("R5 mark good", par_err_o, 0); pulse_rd();
    par_mode_i = 2'd0; send(8'h96, 1, ~^8'h96, 1, 1);
    chk("R5 even bad", par_err_o, 1);
    chk("R5 data", data_o, 8'h96);
    pulse_rd();
    chk("R8 par err survives read", par_err_o, 1);
    pulse_clr();
    chk("R8 par err cleared", par_err_o, 0);
    par_mode_i = 2'd3; send(8'hF0, 1, 1'b0, 1, 1);
    chk("R5 mark bad", par_err_o, 1); pulse_rd(); pulse_clr();

    // R7 + R2: bad stop, line left low
    par_en_i = 0;
    send(8'h5A, 0, 0, 0, 0);
    chk("R7 frm err", frm_err_o, 1);
    chk("R7 ready", ready_o, 1);
    pulse_rd();
    wait_ticks(3 * 10 * OVS);
    chk("R2 stuck low no restart", ready_o, 0);
    chk("R8 frm err sticky", frm_err_o, 1);
    rx_i = 1; wait_ticks(2 * OVS);
    pulse_clr();
    chk("R8 frm err cleared", frm_err_o, 0);

    // R3: glitch
    rx_i = 0; wait_ticks(4); rx_i = 1;
    wait_ticks(12 * OVS);
    chk("R3 glitch ignored", ready_o, 0);

    // R10: overrun
    send(8'h11, 0, 0, 1, 1);
    send(8'h22, 0, 0, 1, 1);
    chk("R10 ovr", ovr_o, 1);
    chk("R10 overwrite", data_o, 8'h22);
    pulse_rd(); pulse_clr();
    chk("R8 ovr cleared", ovr_o, 0);

    // R11: slower tick
    tdiv = 3;
    wait_ticks(2 * OVS);
    par_en_i = 1; par_mode_i = 2'd1;
    send(8'hC3, 1, ~^8'hC3, 1, 1);
    chk("R11 data slow tick", data_o, 8'hC3);
    chk("R11 no errors", {par_err_o, frm_err_o, ovr_o}, 0);
    pulse_rd();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule